// File: doc/BRIEF.md
# Command Ring No-Op Responder

This block sits on the host-controller side of a command ring and an event ring that both live in system memory. Software places 16-byte command entries in the command ring and then writes doorbell entry zero. The block then reads entries one at a time from its current consumer slot. It keeps working while each entry's cycle bit matches its consumer cycle state. For every entry it accepts, it writes one command-completion event into the event ring. That event is tagged with the block's producer cycle bit, carries the address of the command it answers, and holds a completion code.

Only the no-op command is executed. Every other command type is answered with an error code. Both rings are single segments that wrap back to slot zero and toggle their cycle state when they wrap. The block will not overrun the event-ring consumer: it compares its next write slot with a dequeue index supplied from outside. An interrupt output is raised after each posted event and stays high until software acknowledges it.

Top module: `cmd_noop_responder`

## Requirements
- R1: A doorbell write with index 0 starts processing. A doorbell write with any other index causes no memory access and posts no event.
- R2: Entry k of the command ring is read from `cmd_base_i + 16*k`. An entry is processed only when its bit 96 equals the consumer cycle state. That state is 1 after reset and toggles each time slot CMD_DEPTH-1 is passed. The first entry that does not match ends processing, and the block returns to idle.
- R3: Each processed command produces exactly one event, in command order. Event n is written to `evt_base_i + 16*(n mod EVT_DEPTH)`.
- R4: Bits 63:0 of each event hold the address of the command entry it answers.
- R5: Bits 95:88 of each event hold 1 (success) when the command's type field (bits 111:106) is 23, the no-op type. They hold 5 (error) for every other type.
- R6: Each event carries type 33 in bits 111:106 and the producer cycle bit in bit 96. The producer cycle bit is 1 after reset and toggles each time the event ring wraps from slot EVT_DEPTH-1 to slot 0.
- R7: No event is written while the slot after the current write slot equals `evt_deq_idx_i`. The block holds the pending event and posts it once that condition clears.
- R8: `irq_o` goes high in the cycle after an event is written. It stays high until `irq_ack_i` is asserted. An event written in the same cycle as an acknowledge keeps it high.
- R9: At most one of a command read and an event write is active in any cycle. A read request holds its address stable until it is acknowledged.
- R10: After reset, `irq_o`, `cmd_req_o` and `evt_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| db_wr_i | input | 1 | Doorbell write strobe |
| db_idx_i | input | DB_W | Doorbell entry index of the write |
| cmd_base_i | input | AW | Byte address of command-ring slot 0 |
| cmd_req_o | output | 1 | Command entry read request |
| cmd_addr_o | output | AW | Address of the entry being read |
| cmd_ack_i | input | 1 | Read data valid; completes the request |
| cmd_data_i | input | 128 | Command entry read data |
| evt_base_i | input | AW | Byte address of event-ring slot 0 |
| evt_deq_idx_i | input | clog2(EVT_DEPTH) | Event-ring consumer dequeue slot |
| evt_we_o | output | 1 | Event entry write strobe |
| evt_addr_o | output | AW | Address of the event entry written |
| evt_data_o | output | 128 | Event entry write data |
| irq_o | output | 1 | Interrupt, level, held until acknowledged |
| irq_ack_i | input | 1 | Interrupt acknowledge |

## Verification
The assertions check, on every cycle, the rules that a single cycle or one pair of cycles can show. These are: no event write into a full ring; a fixed event type; event addresses that point inside the command ring; reads and writes that never overlap; read requests held steady until acknowledged; and the interrupt set and hold behaviour. Only the bench scenarios can show the rest, because each of these needs a history of many cycles: that event n answers command n; that both cycle states toggle exactly at the wrap; that a stale entry stops the engine; that a doorbell on a nonzero index is ignored; and that a stalled event is posted once the consumer moves on.

// File: rtl/cnr_pkg.sv
package cnr_pkg;
  localparam int ENTRY_W  = 128;
  localparam int CYC_BIT  = 96;
  localparam int TYPE_LSB = 106;
  localparam int TYPE_W   = 6;
  localparam int CODE_LSB = 88;
  localparam int CODE_W   = 8;

  localparam logic [TYPE_W-1:0] TYPE_NOOP_CMD = 6'd23;
  localparam logic [TYPE_W-1:0] TYPE_CMD_DONE = 6'd33;
  localparam logic [CODE_W-1:0] CODE_OK       = 8'd1;
  localparam logic [CODE_W-1:0] CODE_ERR      = 8'd5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_POST
  } state_e;
endpackage

// File: rtl/cnr_ring_ptr.sv
// Slot index plus cycle state for a single-segment ring.
module cnr_ring_ptr #(
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] nxt_o,
  output logic          cyc_o
);
  logic last;

  assign last  = (idx_o == IW'(DEPTH - 1));
  assign nxt_o = last ? '0 : idx_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
      cyc_o <= 1'b1;
    end else if (adv_i) begin
      idx_o <= nxt_o;
      if (last) cyc_o <= ~cyc_o;
    end
  end
endmodule

// File: rtl/cnr_irq_ctl.sv
// Level interrupt; a set wins over an acknowledge in the same cycle.
module cnr_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= set_i | (irq_o & ~ack_i);
  end
endmodule

// File: rtl/cnr_evt_build.sv
module cnr_evt_build import cnr_pkg::*; #(
  parameter int AW = 64
) (
  input  logic [AW-1:0]      cmd_addr_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               cyc_i,
  output logic [ENTRY_W-1:0] evt_o
);
  always_comb begin
    evt_o                         = '0;
    evt_o[63:0]                   = 64'(cmd_addr_i);
    evt_o[CODE_LSB +: CODE_W]     = code_i;
    evt_o[CYC_BIT]                = cyc_i;
    evt_o[TYPE_LSB +: TYPE_W]     = TYPE_CMD_DONE;
  end
endmodule

// File: rtl/cmd_noop_responder.sv
module cmd_noop_responder import cnr_pkg::*; #(
  parameter int CMD_DEPTH = 16,
  parameter int EVT_DEPTH = 16,
  parameter int DB_W      = 8,
  parameter int AW        = 64,
  localparam int CIW = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1,
  localparam int EIW = (EVT_DEPTH > 1) ? $clog2(EVT_DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               db_wr_i,
  input  logic [DB_W-1:0]    db_idx_i,
  input  logic [AW-1:0]      cmd_base_i,
  output logic               cmd_req_o,
  output logic [AW-1:0]      cmd_addr_o,
  input  logic               cmd_ack_i,
  input  logic [ENTRY_W-1:0] cmd_data_i,
  input  logic [AW-1:0]      evt_base_i,
  input  logic [EIW-1:0]     evt_deq_idx_i,
  output logic               evt_we_o,
  output logic [AW-1:0]      evt_addr_o,
  output logic [ENTRY_W-1:0] evt_data_o,
  output logic               irq_o,
  input  logic               irq_ack_i
);
  state_e             state_q, state_d;
  logic               db_pend_q;
  logic [CODE_W-1:0]  code_q;
  logic [CIW-1:0]     cmd_idx, cmd_nxt;
  logic [EIW-1:0]     evt_idx, evt_nxt;
  logic               cmd_cyc, evt_cyc;
  logic               db_hit, owned, evt_full, post;
  logic [TYPE_W-1:0]  cmd_type;
  logic               unused_cmd_bits;

  assign db_hit   = db_wr_i && (db_idx_i == '0);
  assign owned    = (cmd_data_i[CYC_BIT] == cmd_cyc);
  assign cmd_type = cmd_data_i[TYPE_LSB +: TYPE_W];
  assign evt_full = (evt_nxt == evt_deq_idx_i);
  assign post     = (state_q == ST_POST) && !evt_full;
  assign unused_cmd_bits = ^{cmd_data_i, cmd_nxt};

  cnr_ring_ptr #(.DEPTH(CMD_DEPTH)) u_cmd_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (post),
    .idx_o (cmd_idx),
    .nxt_o (cmd_nxt),
    .cyc_o (cmd_cyc)
  );

  cnr_ring_ptr #(.DEPTH(EVT_DEPTH)) u_evt_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (post),
    .idx_o (evt_idx),
    .nxt_o (evt_nxt),
    .cyc_o (evt_cyc)
  );

  cnr_irq_ctl u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (post),
    .ack_i (irq_ack_i),
    .irq_o (irq_o)
  );

  cnr_evt_build #(.AW(AW)) u_build (
    .cmd_addr_i(cmd_addr_o),
    .code_i    (code_q),
    .cyc_i     (evt_cyc),
    .evt_o     (evt_data_o)
  );

  assign cmd_addr_o = cmd_base_i + (AW'(cmd_idx) << 4);
  assign evt_addr_o = evt_base_i + (AW'(evt_idx) << 4);
  assign cmd_req_o  = (state_q == ST_FETCH);
  assign evt_we_o   = post;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (db_hit || db_pend_q) state_d = ST_FETCH;
      ST_FETCH: if (cmd_ack_i) state_d = owned ? ST_POST : ST_IDLE;
      ST_POST:  if (!evt_full) state_d = ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      db_pend_q <= 1'b0;
      code_q    <= '0;
    end else begin
      state_q <= state_d;
      // a doorbell seen mid-batch forces one more ring poll
      if (state_q == ST_IDLE) db_pend_q <= 1'b0;
      else if (db_hit)        db_pend_q <= 1'b1;
      if (state_q == ST_FETCH && cmd_ack_i && owned)
        code_q <= (cmd_type == TYPE_NOOP_CMD) ? CODE_OK : CODE_ERR;
    end
  end
endmodule

// File: rtl/cnr_checker.sv
module cnr_checker import cnr_pkg::*; #(
  parameter int CMD_DEPTH = 16,
  parameter int EVT_DEPTH = 16,
  parameter int AW        = 64,
  localparam int EIW = (EVT_DEPTH > 1) ? $clog2(EVT_DEPTH) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      cmd_base_i,
  input logic               cmd_req_o,
  input logic [AW-1:0]      cmd_addr_o,
  input logic               cmd_ack_i,
  input logic [AW-1:0]      evt_base_i,
  input logic [EIW-1:0]     evt_deq_idx_i,
  input logic               evt_we_o,
  input logic [AW-1:0]      evt_addr_o,
  input logic [ENTRY_W-1:0] evt_data_o,
  input logic               irq_o,
  input logic               irq_ack_i
);
  logic [AW-1:0]  evt_off, par_off;
  logic [EIW-1:0] wr_slot, wr_next;

  assign evt_off = evt_addr_o - evt_base_i;
  assign wr_slot = evt_off[4 +: EIW];
  assign wr_next = (wr_slot == EIW'(EVT_DEPTH - 1)) ? '0 : wr_slot + 1'b1;
  assign par_off = AW'(evt_data_o[63:0]) - cmd_base_i;

  assert_no_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_we_o |-> (wr_next != evt_deq_idx_i));

  assert_evt_type_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_we_o |-> (evt_data_o[TYPE_LSB +: TYPE_W] == TYPE_CMD_DONE));

  assert_param_in_ring_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_we_o |-> (par_off[3:0] == 4'd0 && par_off < AW'(16 * CMD_DEPTH)));

  assert_one_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_req_o, evt_we_o}));

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_addr_o)));

  assert_irq_after_post_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_we_o |=> irq_o);

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !evt_we_o) |=> !irq_o);
endmodule

bind cmd_noop_responder cnr_checker #(
  .CMD_DEPTH(CMD_DEPTH),
  .EVT_DEPTH(EVT_DEPTH),
  .AW       (AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_base_i   (cmd_base_i),
  .cmd_req_o    (cmd_req_o),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_ack_i    (cmd_ack_i),
  .evt_base_i   (evt_base_i),
  .evt_deq_idx_i(evt_deq_idx_i),
  .evt_we_o     (evt_we_o),
  .evt_addr_o   (evt_addr_o),
  .evt_data_o   (evt_data_o),
  .irq_o        (irq_o),
  .irq_ack_i    (irq_ack_i)
);

// File: tb/sim_cmd_noop_responder.sv
`timescale 1ns/1ps
module sim_cmd_noop_responder;
  localparam logic [63:0] CMD_BASE = 64'h0000_0001_0000_1000;
  localparam logic [63:0] EVT_BASE = 64'h0000_0002_0000_2000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         db_wr = 1'b0;
  logic [7:0]   db_idx = '0;
  logic         cmd_req;
  logic [63:0]  cmd_addr;
  logic         cmd_ack;
  logic [127:0] cmd_data;
  logic [3:0]   deq = '0;
  logic         evt_we;
  logic [63:0]  evt_addr;
  logic [127:0] evt_data;
  logic         irq;
  logic         irq_ack = 1'b0;

  logic [127:0] cmd_mem [16];
  logic [127:0] evt_log [64];
  logic [63:0]  evt_log_addr [64];
  int           exp_type [64];
  int           evt_cnt = 0;
  int           cmd_m = 0;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  cmd_noop_responder u0 (
    .clk_i(clk), .rst_ni(rst_n), .db_wr_i(db_wr), .db_idx_i(db_idx),
    .cmd_base_i(CMD_BASE), .cmd_req_o(cmd_req), .cmd_addr_o(cmd_addr),
    .cmd_ack_i(cmd_ack), .cmd_data_i(cmd_data), .evt_base_i(EVT_BASE),
    .evt_deq_idx_i(deq), .evt_we_o(evt_we), .evt_addr_o(evt_addr),
    .evt_data_o(evt_data), .irq_o(irq), .irq_ack_i(irq_ack)
  );

  // zero-wait memory model for the command ring
  assign cmd_ack = cmd_req;
  always_comb begin
    logic [63:0] off;
    off = cmd_addr - CMD_BASE;
    cmd_data = cmd_mem[off[7:4]];
  end

  always @(posedge clk) begin
    if (rst_n && evt_we && evt_cnt < 64) begin
      evt_log[evt_cnt]      <= evt_data;
      evt_log_addr[evt_cnt] <= evt_addr;
      evt_cnt               <= evt_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push_cmd(input int typ);
    logic [127:0] e;
    e = '0;
    e[31:0]    = 32'hA5A5_0000 + 32'(cmd_m);
    e[111:106] = 6'(typ);
    e[96]      = ((cmd_m / 16) % 2 == 0);
    cmd_mem[cmd_m % 16] = e;
    exp_type[cmd_m] = typ;
    cmd_m++;
  endtask

  task automatic ring(input logic [7:0] idx);
    @(negedge clk); db_wr = 1'b1; db_idx = idx;
    @(negedge clk); db_wr = 1'b0; db_idx = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 400 && quiet < 4; i++) begin
      @(negedge clk);
      if (!cmd_req && !evt_we) quiet++; else quiet = 0;
    end
  endtask

  task automatic check_evt(input int n);
    logic [127:0] d;
    d = '0;
    d[63:0]    = CMD_BASE + 64'(16 * (n % 16));
    d[95:88]   = (exp_type[n] == 23) ? 8'd1 : 8'd5;
    d[96]      = ((n / 16) % 2 == 0);
    d[111:106] = 6'd33;
    chk("R3 event address", 128'(evt_log_addr[n]), 128'(EVT_BASE + 64'(16 * (n % 16))));
    chk("R4 command address", 128'(evt_log[n][63:0]), 128'(d[63:0]));
    chk("R5 completion code", 128'(evt_log[n][95:88]), 128'(d[95:88]));
    chk("R6 cycle bit", 128'(evt_log[n][96]), 128'(d[96]));
    chk("R6 full event", evt_log[n], d);
  endtask

  task automatic t_reset();
    chk("R10 irq at reset", 128'(irq), 128'(0));
    chk("R10 read req at reset", 128'(cmd_req), 128'(0));
    chk("R10 write at reset", 128'(evt_we), 128'(0));
  endtask

  task automatic t_wrong_doorbell();
    int req_seen = 0;
    push_cmd(23);
    @(negedge clk); db_wr = 1'b1; db_idx = 8'd3;
    @(negedge clk); db_wr = 1'b0; db_idx = '0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmd_req) req_seen++;
    end
    chk("R1 no read on doorbell 3", 128'(req_seen), 128'(0));
    chk("R1 no event on doorbell 3", 128'(evt_cnt), 128'(0));
  endtask

  task automatic t_single_noop();
    ring(8'd0);
    wait_idle();
    chk("R1 one event on doorbell 0", 128'(evt_cnt), 128'(1));
    check_evt(0);
    chk("R8 irq raised", 128'(irq), 128'(1));
    repeat (5) @(negedge clk);
    chk("R8 irq held", 128'(irq), 128'(1));
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 irq cleared by ack", 128'(irq), 128'(0));
  endtask

  task automatic t_error_cmd();
    push_cmd(9);
    ring(8'd0);
    wait_idle();
    chk("R5 error event count", 128'(evt_cnt), 128'(2));
    check_evt(1);
  endtask

  task automatic t_batch();
    push_cmd(23); push_cmd(40); push_cmd(23);
    deq = 4'(evt_cnt % 16);
    ring(8'd0);
    wait_idle();
    chk("R2 batch stops at stale entry", 128'(evt_cnt), 128'(5));
    for (int n = 2; n < 5; n++) check_evt(n);
    chk("R8 irq pending after batch", 128'(irq), 128'(1));
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 irq cleared after batch", 128'(irq), 128'(0));
  endtask

  task automatic t_wrap_and_stall();
    int base;
    base = evt_cnt;
    deq  = 4'(evt_cnt % 16);
    for (int k = 0; k < 16; k++) push_cmd((k % 3 == 1) ? 12 : 23);
    ring(8'd0);
    repeat (80) @(negedge clk);
    chk("R7 stalled after 15 events", 128'(evt_cnt - base), 128'(15));
    chk("R7 no write while full", 128'(evt_we), 128'(0));
    deq = 4'(evt_cnt % 16);
    wait_idle();
    chk("R7 resumed after dequeue", 128'(evt_cnt - base), 128'(16));
    for (int n = base; n < evt_cnt; n++) check_evt(n);
    chk("R2 stale slot ends run", 128'(cmd_req), 128'(0));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cmd_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_wrong_doorbell();
    t_single_noop();
    t_error_cmd();
    t_batch();
    t_wrap_and_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule